// File: doc/BRIEF.md
# Multi-Level Controller Reset Sequencer

This block turns the reset sources of a network controller into per-domain clear strobes. There are four sources: an asynchronous hardware reset pin and three software port commands, which are full reset, selective reset and self test. The register state of the controller is split into five domains: bus configuration space, the command/receive base registers, setup data, error counters and general registers. Each reset class clears its own subset of these domains with one-cycle pulses, and each class also forces the command and receive engines to idle.

Self test is a fixed sequence. A selective clear comes first. A one-cycle start pulse is then sent to a self-test stub, and the block waits for its done signal or for a timeout. A full software clear comes last. A timeout latches a fail status bit. Frame traffic stays disabled after any reset that wipes setup data, until a configure command reports completion.

The block also holds the two base registers and forms DMA addresses from them by adding a base to an offset. In segmented mode only the low half of the offset is used. A clear of the base domain is therefore visible on the address output.

Top module: `ctl_reset_seq`

## Requirements
- R1: After the synchronized release of `hwRstN`, all five clear strobes and `cuRuIdle` pulse high for exactly one cycle. After that, `trafficEn` is 0 and both base registers are 0. No strobe is high while the pin is held low.
- R2: Opcode 0 (software reset) gives a one-cycle pulse on `clrBases`, `clrSetup`, `clrCounters`, `clrGeneral` and `cuRuIdle` in the cycle after acceptance. `clrPciCfg` stays low.
- R3: Opcode 2 (selective reset) pulses only `clrGeneral` and `cuRuIdle`. Base registers and `trafficEn` keep their values.
- R4: Opcode 1 (self test) runs these steps in order: one cycle of `clrGeneral`+`cuRuIdle`, then one cycle of `testStart`, then a wait for `testDone`. The cycle after `testDone` is seen carries the software-reset strobe set.
- R5: When self test ends with `testDone`, `testFail` is 0, `clrPciCfg` has not pulsed, and bases and `trafficEn` are cleared.
- R6: If `testDone` is not seen within TEST_TIMEOUT wait cycles, `testFail` goes to 1 and the software-reset strobe set still follows. `testFail` survives a software reset and is cleared when the next self test starts.
- R7: `trafficEn` goes to 0 whenever `clrSetup` pulses. It goes to 1 only on a `cfgDone` pulse.
- R8: `dmaAddr` equals the base selected by `addrSel` (0 = command, 1 = receive) plus `offset`. When `segMode` is 1, only `offset[15:0]` is added.
- R9: `busy` is high from the cycle after a command is accepted through the cycle of its last strobe, and is low in the following cycle.
- R10: A command that arrives while `busy` is high is ignored. `cmdError` pulses for the one cycle after it.
- R11: Opcode 3 is reserved. It starts nothing and pulses `cmdError`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hwRstN | input | 1 | Hardware reset pin, active low, asynchronous assert |
| portCmdValid | input | 1 | One-cycle port command strobe |
| portCmdOp | input | 2 | Port command opcode |
| cfgDone | input | 1 | Configure command completed pulse |
| testDone | input | 1 | Self-test stub done |
| baseWr | input | 1 | Base register write enable |
| baseSel | input | 1 | Base register write select (0 command, 1 receive) |
| baseData | input | 32 | Base register write data |
| addrSel | input | 1 | Base used for address formation |
| offset | input | 32 | Address offset |
| segMode | input | 1 | Use only low 16 offset bits |
| dmaAddr | output | 32 | Formed physical address |
| testStart | output | 1 | Self-test stub start pulse |
| clrPciCfg | output | 1 | Configuration-space clear strobe |
| clrBases | output | 1 | Base register clear strobe |
| clrSetup | output | 1 | Setup data clear strobe |
| clrCounters | output | 1 | Error counter clear strobe |
| clrGeneral | output | 1 | General register clear strobe |
| cuRuIdle | output | 1 | Force command/receive engines idle |
| busy | output | 1 | Sequence in progress |
| cmdError | output | 1 | Rejected command pulse |
| testFail | output | 1 | Self-test timeout status |
| trafficEn | output | 1 | Frame traffic permitted |

## Verification
The bench sends commands in the middle of a self-test wait. A design that did not lock out those commands would restart, or would emit strobes from inside the wait. The bench lets the stub stay silent for the full timeout window and then checks that the fail bit is set and the trailing software clear still happens. An off-by-one counter would end the wait one cycle early or late. The bench also confirms that the fail bit survives a later software reset and is cleared only by the next self test. It checks that a selective reset leaves the bases and the traffic enable untouched, which a design that merged the selective and software strobe sets would break.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    OP_SOFT  = 2'd0,
    OP_TEST  = 2'd1,
    OP_SEL   = 2'd2,
    OP_RSVD  = 2'd3
  } cmd_op_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HWCLR,
    S_SWCLR,
    S_SELCLR,
    S_PRE,
    S_START,
    S_WAIT,
    S_POST
  } seq_state_t;

  typedef struct packed {
    logic pciCfg;
    logic bases;
    logic setup;
    logic counters;
    logic general;
    logic forceIdle;
    logic setFail;
    logic clrFail;
  } ctrl_strobe_t;

endpackage

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int TEST_TIMEOUT = 1024
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         portCmdValid,
  input  logic [1:0]   portCmdOp,
  input  logic         testDone,
  output ctrl_strobe_t strb,
  output logic         testStart,
  output logic         busy,
  output logic         cmdError
);

  localparam int CNT_W = (TEST_TIMEOUT > 1) ? $clog2(TEST_TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TEST_TIMEOUT - 1);

  seq_state_t state, nextState;
  logic [CNT_W-1:0] waitCnt;
  logic timeoutHit;
  cmd_op_t op;

  assign op = cmd_op_t'(portCmdOp);
  assign timeoutHit = (state == S_WAIT) && !testDone && (waitCnt == CNT_LAST);

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (portCmdValid) begin
          unique case (op)
            OP_SOFT: nextState = S_SWCLR;
            OP_TEST: nextState = S_PRE;
            OP_SEL:  nextState = S_SELCLR;
            default: nextState = S_IDLE;
          endcase
        end
      end
      S_PRE:   nextState = S_START;
      S_START: nextState = S_WAIT;
      S_WAIT:  if (testDone || timeoutHit) nextState = S_POST;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_HWCLR;
      waitCnt  <= '0;
      cmdError <= 1'b0;
    end else begin
      state    <= nextState;
      waitCnt  <= (state == S_WAIT) ? waitCnt + 1'b1 : '0;
      cmdError <= portCmdValid && ((state != S_IDLE) || (op == OP_RSVD));
    end
  end

  always_comb begin
    strb = '0;
    unique case (state)
      S_HWCLR: begin
        strb.pciCfg    = rstN;
        strb.bases     = rstN;
        strb.setup     = rstN;
        strb.counters  = rstN;
        strb.general   = rstN;
        strb.forceIdle = rstN;
      end
      S_SWCLR, S_POST: begin
        strb.bases     = 1'b1;
        strb.setup     = 1'b1;
        strb.counters  = 1'b1;
        strb.general   = 1'b1;
        strb.forceIdle = 1'b1;
      end
      S_SELCLR: begin
        strb.general   = 1'b1;
        strb.forceIdle = 1'b1;
      end
      S_PRE: begin
        strb.general   = 1'b1;
        strb.forceIdle = 1'b1;
        strb.clrFail   = 1'b1;
      end
      S_WAIT:  strb.setFail = timeoutHit;
      default: strb = '0;
    endcase
  end

  assign testStart = (state == S_START);
  assign busy      = (state != S_IDLE);

endmodule

// File: rtl/rstseq_dpath.sv
module rstseq_dpath
  import rstseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 16,
  parameter int N_BASE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic              cfgDone,
  input  logic              baseWr,
  input  logic [$clog2(N_BASE)-1:0] baseSel,
  input  logic [ADDR_W-1:0] baseData,
  input  logic [$clog2(N_BASE)-1:0] addrSel,
  input  logic [ADDR_W-1:0] offset,
  input  logic              segMode,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic              trafficEn,
  output logic              testFail
);

  localparam int SEL_W = $clog2(N_BASE);

  logic [ADDR_W-1:0] baseReg [N_BASE];
  logic [ADDR_W-1:0] effOffset;

  for (genvar g = 0; g < N_BASE; g++) begin : g_base
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        baseReg[g] <= '0;
      else if (strb.bases)
        baseReg[g] <= '0;
      else if (baseWr && (baseSel == SEL_W'(g)))
        baseReg[g] <= baseData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trafficEn <= 1'b0;
      testFail  <= 1'b0;
    end else begin
      if (strb.setup)  trafficEn <= 1'b0;
      else if (cfgDone) trafficEn <= 1'b1;
      if (strb.setFail)      testFail <= 1'b1;
      else if (strb.clrFail) testFail <= 1'b0;
    end
  end

  assign effOffset = segMode ? {{(ADDR_W-SEG_W){1'b0}}, offset[SEG_W-1:0]} : offset;
  assign dmaAddr   = baseReg[addrSel] + effOffset;

endmodule

// File: rtl/ctl_reset_seq.sv
module ctl_reset_seq
  import rstseq_pkg::*;
#(
  parameter int TEST_TIMEOUT = 1024,
  parameter int ADDR_W       = 32,
  parameter int SEG_W        = 16
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  logic              portCmdValid,
  input  logic [1:0]        portCmdOp,
  input  logic              cfgDone,
  input  logic              testDone,
  input  logic              baseWr,
  input  logic              baseSel,
  input  logic [ADDR_W-1:0] baseData,
  input  logic              addrSel,
  input  logic [ADDR_W-1:0] offset,
  input  logic              segMode,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic              testStart,
  output logic              clrPciCfg,
  output logic              clrBases,
  output logic              clrSetup,
  output logic              clrCounters,
  output logic              clrGeneral,
  output logic              cuRuIdle,
  output logic              busy,
  output logic              cmdError,
  output logic              testFail,
  output logic              trafficEn
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rstSyncQ;
  logic rstSyncN;
  ctrl_strobe_t strb;

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) rstSyncQ <= '0;
    else         rstSyncQ <= {rstSyncQ[SYNC_STAGES-2:0], 1'b1};
  end
  assign rstSyncN = rstSyncQ[SYNC_STAGES-1];

  rstseq_ctrl #(.TEST_TIMEOUT(TEST_TIMEOUT)) ctrl_i (
    .clk(clk), .rstN(rstSyncN), .portCmdValid(portCmdValid), .portCmdOp(portCmdOp),
    .testDone(testDone), .strb(strb), .testStart(testStart), .busy(busy),
    .cmdError(cmdError)
  );

  rstseq_dpath #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .N_BASE(2)) dpath_i (
    .clk(clk), .rstN(rstSyncN), .strb(strb), .cfgDone(cfgDone),
    .baseWr(baseWr), .baseSel(baseSel), .baseData(baseData),
    .addrSel(addrSel), .offset(offset), .segMode(segMode),
    .dmaAddr(dmaAddr), .trafficEn(trafficEn), .testFail(testFail)
  );

  assign clrPciCfg   = strb.pciCfg;
  assign clrBases    = strb.bases;
  assign clrSetup    = strb.setup;
  assign clrCounters = strb.counters;
  assign clrGeneral  = strb.general;
  assign cuRuIdle    = strb.forceIdle;

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
  input logic clk,
  input logic rstN,
  input logic portCmdValid,
  input logic cfgDone,
  input logic clrPciCfg,
  input logic clrBases,
  input logic clrSetup,
  input logic clrCounters,
  input logic clrGeneral,
  input logic cuRuIdle,
  input logic busy,
  input logic testStart,
  input logic testFail,
  input logic trafficEn,
  input logic cmdError
);

  assert_full_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    clrPciCfg |-> (clrBases && clrSetup && clrCounters && clrGeneral && cuRuIdle));

  assert_soft_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    clrBases |-> (clrSetup && clrCounters && clrGeneral && cuRuIdle));

  assert_general_idles_R3: assert property (@(posedge clk) disable iff (!rstN)
    clrGeneral |-> cuRuIdle);

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    testStart |=> !testStart);

  assert_timeout_post_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testFail) |-> clrBases);

  assert_traffic_cfg_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trafficEn) |-> $past(cfgDone));

  assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clrPciCfg || clrBases || clrSetup || clrCounters || clrGeneral || testStart) |-> busy);

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> $past(portCmdValid));

endmodule

bind ctl_reset_seq rstseq_checker chk_i (
  .clk(clk), .rstN(rstSyncN), .portCmdValid(portCmdValid), .cfgDone(cfgDone),
  .clrPciCfg(clrPciCfg), .clrBases(clrBases), .clrSetup(clrSetup),
  .clrCounters(clrCounters), .clrGeneral(clrGeneral), .cuRuIdle(cuRuIdle),
  .busy(busy), .testStart(testStart), .testFail(testFail),
  .trafficEn(trafficEn), .cmdError(cmdError)
);

// File: tb/ctl_reset_seq_tb_top.sv
module ctl_reset_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 1024;

  logic clk = 1'b0;
  logic hwRstN = 1'b0;
  logic portCmdValid = 1'b0;
  logic [1:0] portCmdOp = 2'd0;
  logic cfgDone = 1'b0, testDone = 1'b0;
  logic baseWr = 1'b0, baseSel = 1'b0, addrSel = 1'b0, segMode = 1'b0;
  logic [31:0] baseData = '0, offset = '0;
  logic [31:0] dmaAddr;
  logic testStart, clrPciCfg, clrBases, clrSetup, clrCounters, clrGeneral, cuRuIdle;
  logic busy, cmdError, testFail, trafficEn;

  int nChecks = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_reset_seq #(.TEST_TIMEOUT(TIMEOUT)) dut_i (
    .clk(clk), .hwRstN(hwRstN), .portCmdValid(portCmdValid), .portCmdOp(portCmdOp),
    .cfgDone(cfgDone), .testDone(testDone), .baseWr(baseWr), .baseSel(baseSel),
    .baseData(baseData), .addrSel(addrSel), .offset(offset), .segMode(segMode),
    .dmaAddr(dmaAddr), .testStart(testStart), .clrPciCfg(clrPciCfg),
    .clrBases(clrBases), .clrSetup(clrSetup), .clrCounters(clrCounters),
    .clrGeneral(clrGeneral), .cuRuIdle(cuRuIdle), .busy(busy),
    .cmdError(cmdError), .testFail(testFail), .trafficEn(trafficEn)
  );

  // strobe vector: {pci, bases, setup, counters, general, idle}
  function automatic logic [31:0] strobes();
    return {26'd0, clrPciCfg, clrBases, clrSetup, clrCounters, clrGeneral, cuRuIdle};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [1:0] op);
    @(negedge clk); portCmdValid = 1'b1; portCmdOp = op;
    @(negedge clk); portCmdValid = 1'b0;
  endtask

  task automatic writeBase(input logic sel, input logic [31:0] val);
    @(negedge clk); baseWr = 1'b1; baseSel = sel; baseData = val;
    @(negedge clk); baseWr = 1'b0;
  endtask

  task automatic pulseCfg();
    @(negedge clk); cfgDone = 1'b1;
    @(negedge clk); cfgDone = 1'b0;
  endtask

  task automatic testHwReset();
    repeat (3) @(negedge clk);
    chk("R1", "strobes held in reset", strobes(), 32'h0);
    hwRstN = 1'b1;
    @(negedge clk);
    chk("R1", "strobes during sync", strobes(), 32'h0);
    @(negedge clk);
    chk("R1", "hw clear set", strobes(), 32'h3F);
    chk("R9", "busy in hw clear", busy, 1'b1);
    @(negedge clk);
    chk("R1", "strobes drop", strobes(), 32'h0);
    chk("R9", "busy drop", busy, 1'b0);
    chk("R7", "traffic after hw", trafficEn, 1'b0);
    addrSel = 1'b1; offset = 32'h0; #1;
    chk("R1", "receive base zero", dmaAddr, 32'h0);
  endtask

  task automatic testAddr();
    writeBase(1'b0, 32'h1000_0000);
    writeBase(1'b1, 32'h0002_0000);
    addrSel = 1'b0; segMode = 1'b0; offset = 32'h0001_2345; #1;
    chk("R8", "linear command", dmaAddr, 32'h1001_2345);
    addrSel = 1'b1; segMode = 1'b1; offset = 32'hABCD_1234; #1;
    chk("R8", "segmented receive", dmaAddr, 32'h0002_1234);
    segMode = 1'b0; #1;
    chk("R8", "linear receive", dmaAddr, 32'hABCF_1234);
  endtask

  task automatic testSelective();
    pulseCfg();
    chk("R7", "traffic after cfg", trafficEn, 1'b1);
    sendCmd(2'd2);
    chk("R3", "selective set", strobes(), 32'h03);
    chk("R9", "busy selective", busy, 1'b1);
    @(negedge clk);
    chk("R9", "busy end selective", busy, 1'b0);
    chk("R3", "strobes end", strobes(), 32'h0);
    addrSel = 1'b0; offset = 32'h10; #1;
    chk("R3", "base kept", dmaAddr, 32'h1000_0010);
    chk("R3", "traffic kept", trafficEn, 1'b1);
  endtask

  task automatic testSoft();
    sendCmd(2'd0);
    chk("R2", "soft set", strobes(), 32'h1F);
    @(negedge clk);
    chk("R2", "soft end", strobes(), 32'h0);
    chk("R9", "busy after soft", busy, 1'b0);
    chk("R2", "base cleared", dmaAddr, 32'h10);
    chk("R7", "traffic cleared", trafficEn, 1'b0);
  endtask

  task automatic testSelfDone();
    writeBase(1'b0, 32'h4000_0000);
    pulseCfg();
    sendCmd(2'd1);
    chk("R4", "pre set", strobes(), 32'h03);
    chk("R4", "no start yet", testStart, 1'b0);
    @(negedge clk);
    chk("R4", "start pulse", testStart, 1'b1);
    chk("R4", "no strobes at start", strobes(), 32'h0);
    @(negedge clk);
    chk("R4", "start one cycle", testStart, 1'b0);
    repeat (4) @(negedge clk);
    sendCmd(2'd0);
    chk("R10", "error pulse", cmdError, 1'b1);
    chk("R10", "no strobes from busy cmd", strobes(), 32'h0);
    chk("R10", "still busy", busy, 1'b1);
    @(negedge clk);
    chk("R10", "error one cycle", cmdError, 1'b0);
    testDone = 1'b1;
    @(negedge clk); testDone = 1'b0;
    chk("R4", "post set", strobes(), 32'h1F);
    chk("R5", "no fail", testFail, 1'b0);
    @(negedge clk);
    chk("R9", "busy after test", busy, 1'b0);
    addrSel = 1'b0; offset = 32'h20; #1;
    chk("R5", "base cleared", dmaAddr, 32'h20);
    chk("R5", "traffic cleared", trafficEn, 1'b0);
  endtask

  task automatic testReserved();
    sendCmd(2'd3);
    chk("R11", "reserved error", cmdError, 1'b1);
    chk("R11", "reserved not busy", busy, 1'b0);
    chk("R11", "reserved no strobes", strobes(), 32'h0);
    @(negedge clk);
    chk("R11", "reserved error clear", cmdError, 1'b0);
  endtask

  task automatic testTimeout();
    sendCmd(2'd1);
    @(negedge clk);
    chk("R6", "start", testStart, 1'b1);
    @(negedge clk);
    repeat (TIMEOUT - 1) @(negedge clk);
    chk("R6", "last wait cycle quiet", strobes(), 32'h0);
    chk("R6", "fail not yet", testFail, 1'b0);
    chk("R6", "busy in wait", busy, 1'b1);
    @(negedge clk);
    chk("R6", "post after timeout", strobes(), 32'h1F);
    chk("R6", "fail set", testFail, 1'b1);
    @(negedge clk);
    chk("R6", "idle after timeout", busy, 1'b0);
    sendCmd(2'd0);
    @(negedge clk);
    chk("R6", "fail survives soft", testFail, 1'b1);
    sendCmd(2'd1);
    @(negedge clk);
    chk("R6", "fail cleared by new test", testFail, 1'b0);
    @(negedge clk);
    testDone = 1'b1;
    @(negedge clk); testDone = 1'b0;
    chk("R5", "post after done", strobes(), 32'h1F);
    @(negedge clk);
    chk("R5", "fail stays clear", testFail, 1'b0);
  endtask

  initial begin
    testHwReset();
    testAddr();
    testSelective();
    testSoft();
    testSelfDone();
    testReserved();
    testTimeout();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule